// File: doc/BRIEF.md
# Watchdog Timer with Frequency-Select Revert

This block guards a software-driven change of the clock frequency. Software loads a 4-bit timeout code. A nonzero code starts a countdown. Each code step is worth a fixed number of prescaled reference-clock ticks. If software does not write the code back to zero, or reload it, before the count runs out, the block expires. It then pulls the active-low system reset low for a fixed number of cycles and sets a sticky time-out flag.

The block also owns the choice of frequency code. A 5-bit pin code is captured while the active-low power-good strobe is held low. An override state picks between that captured code and a 5-bit software code. On expiry, a revert-select input is copied into the override state. A revert-select of 0 restores the pin code, and a revert-select of 1 keeps the software code.

Top module: `wdt_freq_revert`

## Requirements
- R1: While `pwrgd_ni` is 0, the latched pin code takes `fs_pins_i` on every clock. While `pwrgd_ni` is 1, the latched pin code holds its value.
- R2: When the override state is 0, `fs_active_o` equals the latched pin code. When it is 1, `fs_active_o` equals `sw_fsel_i`. A pulse on `ovr_wr_i` loads `ovr_val_i` into the override state.
- R3: A timer write with code C≠0 starts or restarts a countdown of C×UNIT_TICKS ticks. One tick occurs every PRESCALE clocks; the first tick is on the PRESCALE-th clock edge after reset release. A write of 0 stops the countdown, and no expiry follows.
- R4: When the countdown runs out, `sys_rst_no` is 0 for exactly PULSE_CYC cycles, starting in the cycle after the expiring edge.
- R5: `wdt_flag_o` becomes 1 on expiry and stays 1 until a `flag_clr_i` pulse. If expiry and a clear fall in the same cycle, the flag is set.
- R6: On expiry, the override state takes `revert_sel_i`. This takes priority over an `ovr_wr_i` in the same cycle.
- R7: A timer write in the cycle the count would run out cancels that expiry and takes effect instead.
- R8: Timer writes while `sys_rst_no` is 0 are ignored. After the pulse the timer stays idle until it is re-armed.
- R9: After reset, `sys_rst_no` is 1, `wdt_flag_o` is 0, the override state is 0, the latched code is 0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_pins_i | input | 5 | Hardware frequency-select pins |
| pwrgd_ni | input | 1 | Power-good strobe, latch transparent while low |
| sw_fsel_i | input | 5 | Software frequency code |
| ovr_wr_i | input | 1 | Write strobe for the override state |
| ovr_val_i | input | 1 | Override value (1 selects the software code) |
| revert_sel_i | input | 1 | Override value applied on expiry |
| tmr_wr_i | input | 1 | Timer code write strobe |
| tmr_code_i | input | 4 | Timer code, 0 stops the timer |
| flag_clr_i | input | 1 | Clears the time-out flag |
| sys_rst_no | output | 1 | System reset pulse, active low |
| wdt_flag_o | output | 1 | Sticky time-out flag |
| fs_active_o | output | 5 | Selected frequency code |

## Verification
Two pairs of events can land on the same edge. A software timer write can fall in the cycle the count runs out, and a flag clear can fall in the cycle of expiry. The bench uses its reference model to find the exact cycle in which the last tick falls, and it drives the write or the clear into that cycle. It judges the result at the ports. A reload must give no reset pulse and no flag change. A clear must leave the flag set and start the pulse as usual.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned FS_W   = 5;

  typedef struct packed {
    logic              wr;
    logic [CODE_W-1:0] code;
  } tmr_req_t;
endpackage

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
`timescale 1ns/1ps
module wdt_countdown
  import wdt_pkg::*;
#(
  parameter int unsigned UNIT_TICKS = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  tmr_req_t req_i,
  input  logic     block_i,
  output logic     expire_o,
  output logic     running_o
);
  localparam int unsigned MAX_CNT = ((1 << CODE_W) - 1) * UNIT_TICKS;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] UNIT_C = CNT_W'(UNIT_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             wr_ok;

  assign wr_ok    = req_i.wr & ~block_i;
  // a write landing on the last tick wins over expiry
  assign expire_o = run_q & tick_i & (cnt_q == CNT_W'(1)) & ~wr_ok;
  assign running_o = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (wr_ok) begin
      cnt_q <= CNT_W'(req_i.code) * UNIT_C;
      run_q <= (req_i.code != '0);
    end else if (expire_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rst_pulse_gen.sv
`timescale 1ns/1ps
module rst_pulse_gen #(
  parameter int unsigned PULSE_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic flag_clr_i,
  output logic sys_rst_no,
  output logic flag_o,
  output logic busy_o
);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);
  logic [PW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (fire_i)      cnt_q <= PW'(PULSE_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (fire_i)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign busy_o     = (cnt_q != '0);
  assign sys_rst_no = ~busy_o;
  assign flag_o     = flag_q;
endmodule

// File: rtl/fs_src_sel.sv
`timescale 1ns/1ps
module fs_src_sel
  import wdt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_pins_i,
  input  logic            pwrgd_ni,
  input  logic [FS_W-1:0] sw_fsel_i,
  input  logic            ovr_wr_i,
  input  logic            ovr_val_i,
  input  logic            revert_i,
  input  logic            revert_sel_i,
  output logic [FS_W-1:0] lat_o,
  output logic            ovr_o,
  output logic [FS_W-1:0] fs_o
);
  logic [FS_W-1:0] lat_q;
  logic            ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lat_q <= '0;
    else if (!pwrgd_ni) lat_q <= fs_pins_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (revert_i) ovr_q <= revert_sel_i;
    else if (ovr_wr_i) ovr_q <= ovr_val_i;
  end

  assign lat_o = lat_q;
  assign ovr_o = ovr_q;
  assign fs_o  = ovr_q ? sw_fsel_i : lat_q;
endmodule

// File: rtl/wdt_freq_revert.sv
`timescale 1ns/1ps
module wdt_freq_revert
  import wdt_pkg::*;
#(
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned UNIT_TICKS = 5,
  parameter int unsigned PULSE_CYC  = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FS_W-1:0] fs_pins_i,
  input  logic            pwrgd_ni,
  input  logic [FS_W-1:0] sw_fsel_i,
  input  logic            ovr_wr_i,
  input  logic            ovr_val_i,
  input  logic            revert_sel_i,
  input  logic            tmr_wr_i,
  input  logic [CODE_W-1:0] tmr_code_i,
  input  logic            flag_clr_i,
  output logic            sys_rst_no,
  output logic            wdt_flag_o,
  output logic [FS_W-1:0] fs_active_o
);
  logic            tick;
  logic            expire;
  logic            running;
  logic            busy;
  logic [FS_W-1:0] fs_lat;
  logic            ovr_q;
  tmr_req_t        req;

  assign req.wr   = tmr_wr_i;
  assign req.code = tmr_code_i;

  wdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  wdt_countdown #(.UNIT_TICKS(UNIT_TICKS)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .req_i(req),
    .block_i(busy), .expire_o(expire), .running_o(running)
  );

  rst_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(expire), .flag_clr_i(flag_clr_i),
    .sys_rst_no(sys_rst_no), .flag_o(wdt_flag_o), .busy_o(busy)
  );

  fs_src_sel u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .fs_pins_i(fs_pins_i), .pwrgd_ni(pwrgd_ni),
    .sw_fsel_i(sw_fsel_i), .ovr_wr_i(ovr_wr_i), .ovr_val_i(ovr_val_i),
    .revert_i(expire), .revert_sel_i(revert_sel_i),
    .lat_o(fs_lat), .ovr_o(ovr_q), .fs_o(fs_active_o)
  );
endmodule

// File: rtl/wdt_freq_revert_chk.sv
`timescale 1ns/1ps
module wdt_freq_revert_chk #(
  parameter int unsigned PULSE_CYC = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwrgd_ni,
  input logic       revert_sel_i,
  input logic       tmr_wr_i,
  input logic [3:0] tmr_code_i,
  input logic       flag_clr_i,
  input logic       sys_rst_no,
  input logic       wdt_flag_o,
  input logic       expire_i,
  input logic       running_i,
  input logic [4:0] fs_lat_i,
  input logic       ovr_i
);
  logic [15:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         low_cnt <= '0;
    else if (!sys_rst_no) low_cnt <= low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrgd_ni |=> $stable(fs_lat_i)); // R1
  AST_ARM_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_wr_i && tmr_code_i != 4'd0 && sys_rst_no) |=> running_i); // R3
  AST_ZERO_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_wr_i && tmr_code_i == 4'd0 && sys_rst_no) |=> !running_i && sys_rst_no); // R3
  AST_EXPIRE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> !sys_rst_no && wdt_flag_o); // R4
  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> low_cnt == 16'(PULSE_CYC)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_flag_o && !flag_clr_i) |=> wdt_flag_o); // R5
  AST_REVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> ovr_i == $past(revert_sel_i)); // R6
  AST_IDLE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_no |-> !running_i); // R8
endmodule

bind wdt_freq_revert wdt_freq_revert_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwrgd_ni(pwrgd_ni), .revert_sel_i(revert_sel_i),
  .tmr_wr_i(tmr_wr_i), .tmr_code_i(tmr_code_i), .flag_clr_i(flag_clr_i),
  .sys_rst_no(sys_rst_no), .wdt_flag_o(wdt_flag_o), .expire_i(expire),
  .running_i(running), .fs_lat_i(fs_lat), .ovr_i(ovr_q)
);

// File: tb/wdt_freq_revert_bench.sv
`timescale 1ns/1ps
module wdt_freq_revert_bench;
  localparam int P = 4, U = 5, PC = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] fs_pins_i = '0, sw_fsel_i = '0;
  logic pwrgd_ni = 1'b1, ovr_wr_i = 1'b0, ovr_val_i = 1'b0, revert_sel_i = 1'b0;
  logic tmr_wr_i = 1'b0, flag_clr_i = 1'b0;
  logic [3:0] tmr_code_i = '0;
  logic sys_rst_no, wdt_flag_o;
  logic [4:0] fs_active_o;

  int checks = 0, errors = 0, cyc_total = 0;
  int m_cyc, m_rem, m_pulse, m_flag, m_ovr, m_lat;

  always #2.5 clk = ~clk;

  wdt_freq_revert #(.PRESCALE(P), .UNIT_TICKS(U), .PULSE_CYC(PC)) u_wdt_freq_revert (
    .clk_i(clk), .rst_ni(rst_ni), .fs_pins_i(fs_pins_i), .pwrgd_ni(pwrgd_ni),
    .sw_fsel_i(sw_fsel_i), .ovr_wr_i(ovr_wr_i), .ovr_val_i(ovr_val_i),
    .revert_sel_i(revert_sel_i), .tmr_wr_i(tmr_wr_i), .tmr_code_i(tmr_code_i),
    .flag_clr_i(flag_clr_i), .sys_rst_no(sys_rst_no), .wdt_flag_o(wdt_flag_o),
    .fs_active_o(fs_active_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each edge, compared 1 ns later
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cyc = 0; m_rem = 0; m_pulse = 0; m_flag = 0; m_ovr = 0; m_lat = 0;
    end else begin
      bit tk, ex, wr_ok;
      tk = (m_cyc % P) == P - 1;
      wr_ok = tmr_wr_i && m_pulse == 0;
      ex = m_rem == 1 && tk && !wr_ok;
      if (wr_ok) m_rem = tmr_code_i * U;
      else if (ex) m_rem = 0;
      else if (tk && m_rem > 0) m_rem--;
      if (ex) m_pulse = PC; else if (m_pulse > 0) m_pulse--;
      if (ex) m_flag = 1; else if (flag_clr_i) m_flag = 0;
      if (ex) m_ovr = revert_sel_i; else if (ovr_wr_i) m_ovr = ovr_val_i;
      if (!pwrgd_ni) m_lat = fs_pins_i;
      m_cyc++;
      #1;
      chk("R4", sys_rst_no, m_pulse == 0);
      chk("R5", wdt_flag_o, m_flag);
      chk("R2", fs_active_o, m_ovr ? sw_fsel_i : m_lat);
    end
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tmr(input int code);
    tmr_code_i = 4'(code); tmr_wr_i = 1'b1;
    @(negedge clk); tmr_wr_i = 1'b0;
  endtask

  task automatic wr_ovr(input bit v);
    ovr_val_i = v; ovr_wr_i = 1'b1;
    @(negedge clk); ovr_wr_i = 1'b0;
  endtask

  task automatic wait_last_tick();
    while (!(m_rem == 1 && (m_cyc % P) == P - 1)) @(negedge clk);
  endtask

  task automatic wait_pulse_end();
    int g = 0;
    while (sys_rst_no && g < 2000) begin @(negedge clk); g++; end
    while (!sys_rst_no) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk("R9", sys_rst_no, 1); chk("R9", wdt_flag_o, 0); chk("R9", fs_active_o, 0);
    rst_ni = 1'b1;
    cyc(2);
    chk("R9", sys_rst_no, 1);

    // R1 pin latch
    fs_pins_i = 5'h15; pwrgd_ni = 1'b0; cyc(2);
    pwrgd_ni = 1'b1; fs_pins_i = 5'h0A; cyc(3);
    chk("R1", fs_active_o, 5'h15);

    // R2 override
    sw_fsel_i = 5'h07; wr_ovr(1'b1);
    chk("R2", fs_active_o, 5'h07);
    wr_ovr(1'b0);
    chk("R2", fs_active_o, 5'h15);

    // R3 reload and stop
    wr_tmr(2); cyc(20); wr_tmr(2); cyc(30);
    chk("R3", sys_rst_no, 1);
    wr_tmr(0); cyc(100);
    chk("R3", sys_rst_no, 1); chk("R3", wdt_flag_o, 0);

    // R4 R5 R6 R8 expiry with revert to pins, write ignored during pulse
    wr_ovr(1'b1); revert_sel_i = 1'b0;
    wr_tmr(1);
    begin
      int g = 0, lows = 0;
      while (sys_rst_no && g < 200) begin @(negedge clk); g++; end
      while (!sys_rst_no) begin
        lows++;
        tmr_code_i = 4'd1; tmr_wr_i = (lows == 3);
        @(negedge clk);
      end
      tmr_wr_i = 1'b0;
      chk("R4", lows, PC);
    end
    chk("R5", wdt_flag_o, 1);
    chk("R6", fs_active_o, 5'h15);
    cyc(60);
    chk("R8", sys_rst_no, 1);
    chk("R5", wdt_flag_o, 1);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R5", wdt_flag_o, 0);

    // R6 revert to software code
    revert_sel_i = 1'b1; wr_tmr(1); wait_pulse_end();
    chk("R6", fs_active_o, 5'h07);
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;

    // R7 write in the expiring cycle cancels expiry
    wr_tmr(1); wait_last_tick();
    tmr_code_i = 4'd3; tmr_wr_i = 1'b1; cyc(1); tmr_wr_i = 1'b0;
    cyc(30);
    chk("R7", sys_rst_no, 1); chk("R7", wdt_flag_o, 0);
    wr_tmr(0);

    // R5 clear in the expiring cycle loses to set
    revert_sel_i = 1'b0; wr_tmr(1); wait_last_tick();
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    chk("R5", wdt_flag_o, 1); chk("R4", sys_rst_no, 0);
    wait_pulse_end(); cyc(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule